// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a video output on a single pixel clock. Its horizontal and vertical geometry comes from live inputs rather than from elaboration-time constants. Each axis receives four numbers, all counted from the first visible position: the visible count, the end of the front porch, the end of the sync pulse and the period. The numbers must rise strictly, and the visible count must be at least 10. From these inputs the block runs a horizontal pixel counter and a vertical line counter. It drives active-low horizontal and vertical sync.

An upstream pixel source is paced by three registered strobes. The read strobe is high on every cycle in which a visible pixel is consumed. The end-of-line strobe marks the last visible pixel of every line. The end-of-frame strobe marks the last visible pixel of the last visible line. The read strobe stays low for the whole first frame after reset, so the source always sees an end-of-frame marker before it has to deliver a pixel.

A select input routes the colour outputs from either the external pixel input or an internal test source.

All registered outputs line up with the counter position held in the same cycle. Changes on the mode inputs take effect at the next clock edge. The counters recover by themselves when the geometry shrinks.

Top module: `vtg_timing_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, hsync_n and vsync_n are 1 and rd, eol and eof are 0. Both position counters restart at 0.
- R2: hsync_n is 0 exactly while the horizontal position is at least h_fp_end and below h_sync_end. It is 1 at every other position.
- R3: The vertical position moves on by one line, wrapping after v_total-1, only on the cycle in which the horizontal position becomes h_fp_end. vsync_n is 0 exactly while the vertical position is at least v_fp_end and below v_sync_end.
- R4: The horizontal position goes back to 0 on the clock after it is at or above h_total-1. Otherwise it increments by one. When the period shrinks below the current position, the next position is therefore 0.
- R5: eol is 1 for exactly one cycle per line, at horizontal position h_vis-1. This includes lines in vertical blanking, so it fires v_total times per frame.
- R6: eof is 1 only at horizontal position h_vis-1 of vertical line v_vis-1, once per frame, and never without eol.
- R7: After the first frame, rd is 1 exactly at positions with horizontal position below h_vis and vertical position below v_vis. It falls on position h_vis.
- R8: rd stays 0 from reset until after the first eof pulse.
- R9: With test_sel at 1, red/grn/blu equal tst_r/tst_g/tst_b. With test_sel at 0 they equal ext_r/ext_g/ext_b, combinationally.
- R10: Mode inputs are not latched. A new value applies to the position computed at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| h_vis | input | 16 | Visible pixels per line |
| h_fp_end | input | 16 | End of horizontal front porch |
| h_sync_end | input | 16 | End of horizontal sync |
| h_total | input | 16 | Pixels per line |
| v_vis | input | 16 | Visible lines per frame |
| v_fp_end | input | 16 | End of vertical front porch (lines) |
| v_sync_end | input | 16 | End of vertical sync (lines) |
| v_total | input | 16 | Lines per frame |
| test_sel | input | 1 | 1 selects the internal test source |
| ext_r | input | 8 | External red |
| ext_g | input | 8 | External green |
| ext_b | input | 8 | External blue |
| tst_r | input | 8 | Test-source red |
| tst_g | input | 8 | Test-source green |
| tst_b | input | 8 | Test-source blue |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| rd | output | 1 | Pixel consumed this cycle |
| eol | output | 1 | Last visible pixel of a line |
| eof | output | 1 | Last visible pixel of a frame |
| red | output | 8 | Red out |
| grn | output | 8 | Green out |
| blu | output | 8 | Blue out |

## Verification
The bench targets the first frame, where a generator that ignores the hold-off would pull pixels before the source has seen end-of-frame. It targets the visible edge of each line, where an unregistered or late pre-read would put rd one pixel past h_vis. It switches the geometry mid-line, both larger and then smaller than the current position. A counter that only wraps on equality would then run off to 65535 and lose sync for thousands of cycles. It also counts end-of-line pulses in vertical blanking, which a design gating eol with the vertical visible flag would drop.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int POS_W = 16;

    typedef logic [POS_W-1:0] pos_t;

    // one axis of mode-line geometry, all counted from first visible position
    typedef struct packed {
        pos_t vis;
        pos_t fp_end;
        pos_t sync_end;
        pos_t total;
    } mode_t;

    // position-derived flags for the value the counter will hold next cycle
    typedef struct packed {
        logic in_vis;
        logic on_last;
    } flags_t;

    function automatic pos_t step_pos(pos_t p, mode_t m);
        return (p >= m.total - pos_t'(1)) ? '0 : p + pos_t'(1);
    endfunction

    function automatic logic sync_level(pos_t p, mode_t m);
        return !((p >= m.fp_end) && (p < m.sync_end));
    endfunction

endpackage

// File: rtl/vtg_axis.sv
module vtg_axis
    import vtg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    input  mode_t  mode,
    output pos_t   pos_nxt,
    output flags_t flg_nxt,
    output logic   sync_n
);

    pos_t pos_q;

    always_comb begin
        pos_nxt        = adv ? step_pos(pos_q, mode) : pos_q;
        flg_nxt.in_vis = (pos_nxt < mode.vis);
        flg_nxt.on_last = (pos_nxt == mode.vis - pos_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            sync_n <= 1'b1;
        end else begin
            pos_q  <= pos_nxt;
            sync_n <= sync_level(pos_nxt, mode);
        end
    end

endmodule

// File: rtl/vtg_strobes.sv
module vtg_strobes
    import vtg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t h_f,
    input  flags_t v_f,
    output logic   rd,
    output logic   eol,
    output logic   eof
);

    logic pre_rd;
    logic eof_d;
    logic hold_q;

    always_comb begin
        pre_rd = h_f.in_vis && v_f.in_vis;
        eof_d  = h_f.on_last && v_f.on_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd     <= 1'b0;
            eol    <= 1'b0;
            eof    <= 1'b0;
            hold_q <= 1'b1;
        end else begin
            rd  <= pre_rd && !hold_q;
            eol <= h_f.on_last;
            eof <= eof_d;
            if (eof) hold_q <= 1'b0;
        end
    end

endmodule

// File: rtl/vtg_pix_mux.sv
module vtg_pix_mux #(
    parameter int COL_W = 8,
    parameter int N_CH  = 3
) (
    input  logic                        sel,
    input  logic [N_CH-1:0][COL_W-1:0]  ext_px,
    input  logic [N_CH-1:0][COL_W-1:0]  tst_px,
    output logic [N_CH-1:0][COL_W-1:0]  out_px
);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign out_px[c] = sel ? tst_px[c] : ext_px[c];
    end

endmodule

// File: rtl/vtg_timing_gen.sv
module vtg_timing_gen
    import vtg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      h_vis,
    input  logic [15:0]      h_fp_end,
    input  logic [15:0]      h_sync_end,
    input  logic [15:0]      h_total,
    input  logic [15:0]      v_vis,
    input  logic [15:0]      v_fp_end,
    input  logic [15:0]      v_sync_end,
    input  logic [15:0]      v_total,
    input  logic             test_sel,
    input  logic [COL_W-1:0] ext_r,
    input  logic [COL_W-1:0] ext_g,
    input  logic [COL_W-1:0] ext_b,
    input  logic [COL_W-1:0] tst_r,
    input  logic [COL_W-1:0] tst_g,
    input  logic [COL_W-1:0] tst_b,
    output logic             hsync_n,
    output logic             vsync_n,
    output logic             rd,
    output logic             eol,
    output logic             eof,
    output logic [COL_W-1:0] red,
    output logic [COL_W-1:0] grn,
    output logic [COL_W-1:0] blu
);

    localparam int N_CH = 3;

    mode_t  h_mode, v_mode;
    pos_t   h_nxt, v_nxt;
    flags_t h_f, v_f;
    logic   v_adv;

    logic [N_CH-1:0][COL_W-1:0] ext_px, tst_px, out_px;

    assign h_mode = '{vis: h_vis, fp_end: h_fp_end, sync_end: h_sync_end, total: h_total};
    assign v_mode = '{vis: v_vis, fp_end: v_fp_end, sync_end: v_sync_end, total: v_total};

    // a line ends for the vertical counter where horizontal sync begins
    assign v_adv = (h_nxt == h_mode.fp_end);

    vtg_axis u_h (
        .clk(clk), .rst(rst), .adv(1'b1), .mode(h_mode),
        .pos_nxt(h_nxt), .flg_nxt(h_f), .sync_n(hsync_n)
    );

    vtg_axis u_v (
        .clk(clk), .rst(rst), .adv(v_adv), .mode(v_mode),
        .pos_nxt(v_nxt), .flg_nxt(v_f), .sync_n(vsync_n)
    );

    vtg_strobes u_stb (
        .clk(clk), .rst(rst), .h_f(h_f), .v_f(v_f),
        .rd(rd), .eol(eol), .eof(eof)
    );

    assign ext_px = {ext_b, ext_g, ext_r};
    assign tst_px = {tst_b, tst_g, tst_r};

    vtg_pix_mux #(.COL_W(COL_W), .N_CH(N_CH)) u_mux (
        .sel(test_sel), .ext_px(ext_px), .tst_px(tst_px), .out_px(out_px)
    );

    assign red = out_px[0];
    assign grn = out_px[1];
    assign blu = out_px[2];

endmodule

// File: rtl/vtg_timing_gen_sva.sv
module vtg_timing_gen_sva (
    input logic        clk,
    input logic        rst,
    input logic [15:0] h_vis,
    input logic        hsync_n,
    input logic        vsync_n,
    input logic        rd,
    input logic        eol,
    input logic        eof
);

    logic seen_eof;

    always_ff @(posedge clk) begin
        if (rst) seen_eof <= 1'b0;
        else if (eof) seen_eof <= 1'b1;
    end

    a_r1_reset_outputs: assert property (@(posedge clk)
        rst |=> (hsync_n && vsync_n && !rd && !eol && !eof));

    a_r6_eof_with_eol: assert property (@(posedge clk) disable iff (rst)
        eof |-> eol);

    a_r5_eol_single: assert property (@(posedge clk) disable iff (rst)
        eol |=> (!eol || !$stable(h_vis)));

    a_r2_no_read_in_sync: assert property (@(posedge clk) disable iff (rst)
        !hsync_n |-> !rd);

    a_r8_hold_first_frame: assert property (@(posedge clk) disable iff (rst)
        rd |-> seen_eof);

endmodule

bind vtg_timing_gen vtg_timing_gen_sva u_sva (
    .clk(clk), .rst(rst), .h_vis(h_vis), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .rd(rd), .eol(eol), .eof(eof)
);

// File: tb/vtg_timing_gen_test.sv
module vtg_timing_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] h_vis, h_fp_end, h_sync_end, h_total;
    logic [15:0] v_vis, v_fp_end, v_sync_end, v_total;
    logic        test_sel = 1'b0;
    logic [7:0]  ext_r = 8'h00, ext_g = 8'h00, ext_b = 8'h00;
    logic [7:0]  tst_r = 8'h00, tst_g = 8'h00, tst_b = 8'h00;
    logic        hsync_n, vsync_n, rd, eol, eof;
    logic [7:0]  red, grn, blu;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference position and hold-off state
    int mh = 0, mv = 0;
    bit first = 1;

    always #2 clk = ~clk;

    vtg_timing_gen uut (
        .clk(clk), .rst(rst),
        .h_vis(h_vis), .h_fp_end(h_fp_end), .h_sync_end(h_sync_end), .h_total(h_total),
        .v_vis(v_vis), .v_fp_end(v_fp_end), .v_sync_end(v_sync_end), .v_total(v_total),
        .test_sel(test_sel),
        .ext_r(ext_r), .ext_g(ext_g), .ext_b(ext_b),
        .tst_r(tst_r), .tst_g(tst_g), .tst_b(tst_b),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .rd(rd), .eol(eol), .eof(eof),
        .red(red), .grn(grn), .blu(blu)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h (h=%0d v=%0d t=%0t)", tag, act, exp, mh, mv, $time);
        end
    endtask

    task automatic set_mode(int hv, int hf, int hs, int ht, int vv, int vf, int vs, int vt);
        h_vis = 16'(hv); h_fp_end = 16'(hf); h_sync_end = 16'(hs); h_total = 16'(ht);
        v_vis = 16'(vv); v_fp_end = 16'(vf); v_sync_end = 16'(vs); v_total = 16'(vt);
    endtask

    // compare outputs against the reference for the current position
    task automatic compare();
        bit vis_h, vis_v;
        vis_h = (mh < int'(h_vis));
        vis_v = (mv < int'(v_vis));
        chk("R2 hsync_n", 32'(hsync_n), 32'(!(mh >= int'(h_fp_end) && mh < int'(h_sync_end))));
        chk("R3 vsync_n", 32'(vsync_n), 32'(!(mv >= int'(v_fp_end) && mv < int'(v_sync_end))));
        chk("R5 eol", 32'(eol), 32'(mh == int'(h_vis) - 1));
        chk("R6 eof", 32'(eof), 32'(mh == int'(h_vis) - 1 && mv == int'(v_vis) - 1));
        if (first) chk("R8 rd held", 32'(rd), 32'(0));
        else       chk("R7 rd", 32'(rd), 32'(vis_h && vis_v));
    endtask

    // one pixel clock: advance the reference with the mode seen at the edge (R4, R3, R10)
    task automatic step();
        bit was_eof;
        int hn;
        @(posedge clk);
        #1;
        was_eof = (mh == int'(h_vis) - 1 && mv == int'(v_vis) - 1);
        hn = (mh >= int'(h_total) - 1) ? 0 : mh + 1;
        if (hn == int'(h_fp_end)) mv = (mv >= int'(v_total) - 1) ? 0 : mv + 1;
        mh = hn;
        if (was_eof) first = 0;
        @(negedge clk);
        compare();
    endtask

    task automatic t_reset();
        set_mode(10, 12, 14, 16, 10, 11, 13, 14);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 hsync_n", 32'(hsync_n), 32'(1));
        chk("R1 vsync_n", 32'(vsync_n), 32'(1));
        chk("R1 rd", 32'(rd), 32'(0));
        chk("R1 eol", 32'(eol), 32'(0));
        chk("R1 eof", 32'(eof), 32'(0));
        rst = 1'b0;
        mh = 0; mv = 0; first = 1;
    endtask

    // whole first frame: rd never rises before eof (R8)
    task automatic t_first_frame();
        int rd_seen = 0;
        for (int i = 0; i < 16 * 14; i++) begin
            step();
            if (first && rd) rd_seen++;
        end
        chk("R8 rd pulses in first frame", 32'(rd_seen), 32'(0));
    endtask

    // steady frames: count strobes per frame (R5, R6, R7)
    task automatic t_steady();
        int n_eol = 0, n_eof = 0, n_rd = 0;
        for (int i = 0; i < 16 * 14; i++) begin
            step();
            n_eol += int'(eol);
            n_eof += int'(eof);
            n_rd  += int'(rd);
        end
        chk("R5 eol per frame", 32'(n_eol), 32'(14));
        chk("R6 eof per frame", 32'(n_eof), 32'(1));
        chk("R7 rd per frame", 32'(n_rd), 32'(100));
    endtask

    // live mode change: grow, then shrink below current position (R4, R10)
    task automatic t_mode_change();
        set_mode(24, 28, 33, 40, 12, 14, 16, 18);
        for (int i = 0; i < 40 * 18 + 7; i++) step();
        while (mh < 20) step();
        set_mode(10, 12, 14, 16, 10, 11, 13, 14);
        step();
        chk("R4 wrap on shrink", 32'(mh), 32'(0));
        for (int i = 0; i < 16 * 14 * 2; i++) step();
    endtask

    task automatic t_colour();
        ext_r = 8'h12; ext_g = 8'h34; ext_b = 8'h56;
        tst_r = 8'hA1; tst_g = 8'hB2; tst_b = 8'hC3;
        test_sel = 1'b0;
        #1;
        chk("R9 ext red", 32'(red), 32'h12);
        chk("R9 ext grn", 32'(grn), 32'h34);
        chk("R9 ext blu", 32'(blu), 32'h56);
        test_sel = 1'b1;
        #1;
        chk("R9 tst red", 32'(red), 32'hA1);
        chk("R9 tst grn", 32'(grn), 32'hB2);
        chk("R9 tst blu", 32'(blu), 32'hC3);
        ext_r = 8'hFF;
        #1;
        chk("R9 ext ignored when test selected", 32'(red), 32'hA1);
    endtask

    initial begin
        t_reset();
        t_first_frame();
        t_steady();
        t_steady();
        t_mode_change();
        t_colour();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule